// File: doc/BRIEF.md
# Bottleneck Waiting-Cycle Table

This block keeps score of which code bottlenecks make threads wait the longest. Cores report two kinds of event, each tagged with a bottleneck identifier: a thread has started waiting on that bottleneck, or a thread has stopped waiting. The table is associative. Every tracked identifier has an entry with a count of threads currently waiting and a running total of thread-waiting cycles. Each clock, every entry's total grows by its present waiter count, so a bottleneck that holds many threads for a long time builds a large total.

A scheduler asks about one identifier at a time through a lookup port. The answer comes one cycle later and says whether the identifier is tracked and whether its total is strictly above a programmable threshold, which means it should be shipped to the large core. The answer also carries the entry's total and waiter count, which the scheduler can use to rank candidates. A periodic decay pulse halves every total, so the ranking follows changes in which bottleneck matters. When an untracked identifier starts waiting, it takes a free entry. If no entry is free, it displaces the entry with the smallest total.

The event input is a valid/ready stream. `ev_ready` is low exactly in cycles where `decay_tick` is high. A producer that sees ready low must hold `ev_valid`, `ev_kind` and `ev_id` unchanged until a cycle in which ready is high, and the event is taken in that cycle. The lookup request, the threshold and the decay pulse are plain control pins with no handshake.

Top module: `bneck_wait_table`

## Requirements
- R1: An event is accepted only in a cycle where `ev_valid` and `ev_ready` are both high. `ev_ready` equals the inverse of `decay_tick`. An event presented during a decay cycle changes no entry and is taken in the first later cycle with ready high.
- R2: An accepted event with `ev_kind`=0 (begin) for a tracked identifier raises that entry's waiter count by one, saturating at 2^CNT_W-1 (63 by default). An accepted event with `ev_kind`=1 (end) lowers the count by one and never goes below 0.
- R3: An accepted begin event for an untracked identifier claims an entry. That entry then holds the identifier, a waiter count of 1 and a total of 0. An end event for an untracked identifier changes nothing, and a later lookup of that identifier still misses.
- R4: In each cycle without decay, every tracked entry's total grows by the waiter count it held at the start of that cycle. The total saturates at all ones of TOT_W bits (32 by default) and does not wrap.
- R5: In a cycle with `decay_tick` high, every total becomes its previous value shifted right by one, and no waiter count is added in that cycle.
- R6: A newly claimed entry is the lowest-index free entry. If no entry is free, it is the entry with the smallest total, with the lower index chosen on a tie. The displaced identifier then misses on lookup.
- R7: A lookup raised in cycle t is answered after the next clock edge, from the table state before that edge. The answer sets `lk_resp_valid`=1 and gives `lk_hit`, `lk_total` and `lk_waiters` (both 0 on a miss), and `lk_remote` = hit AND total > `thresh`. In a cycle after an edge with no request, `lk_resp_valid` is 0.
- R8: An identifier occupies at most one entry at any time, under any mix of events, decay pulses and lookups.
- R9: After reset, no entry is tracked: every lookup misses with zero total, `lk_resp_valid` is 0, and `ev_ready` is 1 while `decay_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Wait event present |
| ev_ready | output | 1 | Event accepted this cycle when high |
| ev_kind | input | 1 | 0 = thread begins waiting, 1 = thread stops waiting |
| ev_id | input | ID_W | Bottleneck identifier of the event |
| decay_tick | input | 1 | Halve all totals this cycle |
| thresh | input | TOT_W | Acceleration threshold (strictly greater triggers remote) |
| lk_valid | input | 1 | Lookup request |
| lk_id | input | ID_W | Identifier to look up |
| lk_resp_valid | output | 1 | Lookup answer present |
| lk_hit | output | 1 | Identifier is tracked |
| lk_remote | output | 1 | Tracked and total above threshold |
| lk_total | output | TOT_W | Waiting-cycle total of the hit entry |
| lk_waiters | output | CNT_W | Waiter count of the hit entry |

## Verification
A corrupted total or waiter count shows in `lk_total` or `lk_waiters` on the very next lookup of that identifier. Because every tracked entry keeps accumulating, a wrong waiter count also drifts its total further every cycle afterwards. A wrong victim choice or a duplicated identifier shows as a lookup miss for an identifier that should have stayed, or as a wrong total for one that was re-claimed, one cycle after the lookup. The bench therefore keeps a behavioural model of the table and compares every lookup answer, with many lookups to force allocation and eviction.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  typedef enum logic {
    EV_BEGIN = 1'b0,
    EV_END   = 1'b1
  } ev_kind_e;
endpackage

// File: rtl/bwt_entry.sv
module bwt_entry #(
  parameter int ID_W  = 16,
  parameter int TOT_W = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             inc,
  input  logic             dec,
  input  logic             decay,
  input  logic [ID_W-1:0]  new_id,
  output logic             vld,
  output logic [ID_W-1:0]  id,
  output logic [CNT_W-1:0] waiters,
  output logic [TOT_W-1:0] total
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [TOT_W-1:0] TOT_MAX = '1;

  logic [TOT_W:0]   sum;
  logic [TOT_W-1:0] acc_next;

  assign sum      = {1'b0, total} + {{(TOT_W + 1 - CNT_W){1'b0}}, waiters};
  assign acc_next = sum[TOT_W] ? TOT_MAX : sum[TOT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld     <= 1'b0;
      id      <= '0;
      waiters <= '0;
      total   <= '0;
    end else if (alloc) begin
      vld     <= 1'b1;
      id      <= new_id;
      waiters <= {{(CNT_W - 1){1'b0}}, 1'b1};
      total   <= '0;
    end else begin
      if (decay)    total <= total >> 1;
      else if (vld) total <= acc_next;
      if (inc && waiters != CNT_MAX) waiters <= waiters + 1'b1;
      else if (dec && waiters != '0) waiters <= waiters - 1'b1;
    end
  end

  // R4: accumulation never wraps below the previous total
  assert_total_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !decay && !alloc) |=> (total >= $past(total)));

  // R5: decay halves the total
  assert_decay_halves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (decay && !alloc) |=> (total == ($past(total) >> 1)));

  // R3: a claimed entry starts with one waiter and an empty total
  assert_alloc_fresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (vld && waiters == 1 && total == '0));
endmodule

// File: rtl/bwt_match.sv
module bwt_match #(
  parameter int N     = 32,
  parameter int ID_W  = 16,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]           vld,
  input  logic [N-1:0][ID_W-1:0] ids,
  input  logic [ID_W-1:0]        key,
  output logic [N-1:0]           hit_vec,
  output logic                   hit,
  output logic [IDX_W-1:0]       idx
);
  always_comb begin
    hit_vec = '0;
    idx     = '0;
    for (int i = 0; i < N; i++) begin
      hit_vec[i] = vld[i] && (ids[i] == key);
      if (hit_vec[i]) idx = idx | IDX_W'(i);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/bwt_victim.sv
module bwt_victim #(
  parameter int N     = 32,
  parameter int TOT_W = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][TOT_W-1:0] totals,
  output logic [IDX_W-1:0]        victim
);
  logic [TOT_W:0] best_key;
  logic [TOT_W:0] key;

  always_comb begin
    best_key = '1;
    victim   = '0;
    key      = '0;
    for (int i = 0; i < N; i++) begin
      key = vld[i] ? {1'b1, totals[i]} : '0;
      if (key < best_key) begin
        best_key = key;
        victim   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/bneck_wait_table.sv
module bneck_wait_table
  import bwt_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ID_W    = 16,
  parameter int TOT_W   = 32,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic             ev_kind,
  input  logic [ID_W-1:0]  ev_id,
  input  logic             decay_tick,
  input  logic [TOT_W-1:0] thresh,
  input  logic             lk_valid,
  input  logic [ID_W-1:0]  lk_id,
  output logic             lk_resp_valid,
  output logic             lk_hit,
  output logic             lk_remote,
  output logic [TOT_W-1:0] lk_total,
  output logic [CNT_W-1:0] lk_waiters
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            vld_v, ev_hit_v, lk_hit_v, inc_v, dec_v, alloc_v;
  logic [ENTRIES-1:0][ID_W-1:0]  id_v;
  logic [ENTRIES-1:0][CNT_W-1:0] cnt_v;
  logic [ENTRIES-1:0][TOT_W-1:0] tot_v;
  logic                          ev_hit, lk_hit_c, accept, is_begin;
  logic [IDX_W-1:0]              ev_idx, lk_idx, victim;

  assign ev_ready = !decay_tick;
  assign accept   = ev_valid && ev_ready;
  assign is_begin = (ev_kind_e'(ev_kind) == EV_BEGIN);

  bwt_match #(.N(ENTRIES), .ID_W(ID_W), .IDX_W(IDX_W)) u_ev_match (
    .vld(vld_v), .ids(id_v), .key(ev_id),
    .hit_vec(ev_hit_v), .hit(ev_hit), .idx(ev_idx)
  );

  bwt_match #(.N(ENTRIES), .ID_W(ID_W), .IDX_W(IDX_W)) u_lk_match (
    .vld(vld_v), .ids(id_v), .key(lk_id),
    .hit_vec(lk_hit_v), .hit(lk_hit_c), .idx(lk_idx)
  );

  bwt_victim #(.N(ENTRIES), .TOT_W(TOT_W), .IDX_W(IDX_W)) u_victim (
    .vld(vld_v), .totals(tot_v), .victim(victim)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign inc_v[g]   = accept && is_begin && ev_hit && (ev_idx == IDX_W'(g));
    assign dec_v[g]   = accept && !is_begin && ev_hit && (ev_idx == IDX_W'(g));
    assign alloc_v[g] = accept && is_begin && !ev_hit && (victim == IDX_W'(g));

    bwt_entry #(.ID_W(ID_W), .TOT_W(TOT_W), .CNT_W(CNT_W)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_v[g]), .inc(inc_v[g]), .dec(dec_v[g]), .decay(decay_tick),
      .new_id(ev_id),
      .vld(vld_v[g]), .id(id_v[g]), .waiters(cnt_v[g]), .total(tot_v[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_resp_valid <= 1'b0;
      lk_hit        <= 1'b0;
      lk_remote     <= 1'b0;
      lk_total      <= '0;
      lk_waiters    <= '0;
    end else begin
      lk_resp_valid <= lk_valid;
      lk_hit        <= lk_valid && lk_hit_c;
      lk_remote     <= lk_valid && lk_hit_c && (tot_v[lk_idx] > thresh);
      lk_total      <= (lk_valid && lk_hit_c) ? tot_v[lk_idx] : '0;
      lk_waiters    <= (lk_valid && lk_hit_c) ? cnt_v[lk_idx] : '0;
    end
  end

  // R8: an identifier never sits in two entries
  assert_unique_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(ev_hit_v) && $onehot0(lk_hit_v)));

  // R6: a free entry is always taken before a tracked one is displaced
  assert_free_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_begin && !ev_hit && !(&vld_v)) |-> !vld_v[victim]);

  // R1: no entry moves on an event during a decay cycle
  assert_no_event_on_decay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    decay_tick |-> (inc_v == '0 && dec_v == '0 && alloc_v == '0));

  // R3: at most one entry claimed per cycle
  assert_single_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_v));

  // R7: an answer follows each request by exactly one cycle
  assert_resp_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_resp_valid);
  assert_no_spurious_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_resp_valid);
endmodule

// File: tb/bneck_wait_table_tb.sv
module bneck_wait_table_tb_top;
  localparam int N    = 32;
  localparam int IDW  = 8;
  localparam int TW   = 12;
  localparam int CW   = 6;
  localparam int TMAX = (1 << TW) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0, ev_kind = 1'b0, decay_tick = 1'b0, lk_valid = 1'b0;
  logic [IDW-1:0] ev_id = '0, lk_id = '0;
  logic [TW-1:0] thresh = '0;
  logic          ev_ready, lk_resp_valid, lk_hit, lk_remote;
  logic [TW-1:0] lk_total;
  logic [CW-1:0] lk_waiters;

  bneck_wait_table #(.ENTRIES(N), .ID_W(IDW), .TOT_W(TW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_id(ev_id), .decay_tick(decay_tick), .thresh(thresh),
    .lk_valid(lk_valid), .lk_id(lk_id), .lk_resp_valid(lk_resp_valid),
    .lk_hit(lk_hit), .lk_remote(lk_remote), .lk_total(lk_total), .lk_waiters(lk_waiters)
  );

  always #10 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string phase   = "R9";

  bit mv[N];
  int mid[N];
  int mw[N];
  int mt[N];
  bit e_valid, e_hit, e_rem;
  int e_tot, e_wait;

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      mv[i] = 0; mid[i] = 0; mw[i] = 0; mt[i] = 0;
    end
    e_valid = 0; e_hit = 0; e_rem = 0; e_tot = 0; e_wait = 0;
  endtask

  task automatic model_step();
    int  hit_i, vic;
    bit  acc;
    e_valid = lk_valid; e_hit = 0; e_rem = 0; e_tot = 0; e_wait = 0;
    if (lk_valid)
      for (int i = 0; i < N; i++)
        if (mv[i] && mid[i] == int'(lk_id)) begin
          e_hit = 1; e_tot = mt[i]; e_wait = mw[i]; e_rem = (mt[i] > int'(thresh));
        end
    acc   = ev_valid && !decay_tick;
    hit_i = -1;
    for (int i = 0; i < N; i++) if (mv[i] && mid[i] == int'(ev_id)) hit_i = i;
    vic = -1;
    for (int i = N - 1; i >= 0; i--) if (!mv[i]) vic = i;
    if (vic < 0) begin
      vic = 0;
      for (int i = 1; i < N; i++) if (mt[i] < mt[vic]) vic = i;
    end
    for (int i = 0; i < N; i++) begin
      if (decay_tick) mt[i] = mt[i] >> 1;
      else if (mv[i]) mt[i] = (mt[i] + mw[i] > TMAX) ? TMAX : mt[i] + mw[i];
    end
    if (acc) begin
      if (hit_i >= 0) begin
        if (!ev_kind && mw[hit_i] < CMAX) mw[hit_i]++;
        else if (ev_kind && mw[hit_i] > 0) mw[hit_i]--;
      end else if (!ev_kind) begin
        mv[vic] = 1; mid[vic] = int'(ev_id); mw[vic] = 1; mt[vic] = 0;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_clear();
    else model_step();
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (lk_resp_valid !== e_valid ||
          (e_valid && (lk_hit !== e_hit || lk_remote !== e_rem ||
                       int'(lk_total) != e_tot || int'(lk_waiters) != e_wait))) begin
        n_fail++;
        $display("FAIL %s lookup: got v=%0b hit=%0b rem=%0b tot=%0d w=%0d expected v=%0b hit=%0b rem=%0b tot=%0d w=%0d",
                 phase, lk_resp_valid, lk_hit, lk_remote, lk_total, lk_waiters,
                 e_valid, e_hit, e_rem, e_tot, e_wait);
      end
    end
  end

  task automatic drive(bit evv, bit kind, int id, bit dk, bit lkv, int lid);
    @(negedge clk);
    ev_valid = evv; ev_kind = kind; ev_id = IDW'(id);
    decay_tick = dk; lk_valid = lkv; lk_id = IDW'(lid);
    #1;
    n_tests++;
    if (ev_ready !== !dk) begin
      n_fail++;
      $display("FAIL R1 ev_ready: got %0b expected %0b", ev_ready, !dk);
    end
  endtask

  task automatic look(int lid);
    drive(0, 0, 0, 0, 1, lid);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    ev_valid = 0; decay_tick = 0; lk_valid = 0;
    repeat (2) @(negedge clk);
    n_tests++;
    if (lk_resp_valid !== 1'b0 || ev_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 reset state: got resp_valid=%0b ready=%0b expected 0 1", lk_resp_valid, ev_ready);
    end
    rst_n = 1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    model_clear();
    do_reset();

    phase = "R9";
    for (int k = 1; k < 5; k++) look(k);

    phase = "R3";
    drive(1, 0, 10, 0, 1, 10);
    for (int k = 0; k < 4; k++) look(10);
    drive(1, 1, 99, 0, 1, 99);
    look(99);
    look(99);

    phase = "R2";
    for (int k = 0; k < 3; k++) drive(1, 0, 10, 0, 1, 10);
    look(10);
    for (int k = 0; k < 70; k++) drive(1, 0, 11, 0, 1, 11);
    look(11);
    for (int k = 0; k < 70; k++) drive(1, 1, 11, 0, 1, 11);
    look(11);

    phase = "R4";
    for (int k = 0; k < 70; k++) drive(1, 0, 12, 0, 1, 12);
    for (int k = 0; k < 40; k++) look(12);

    phase = "R5";
    drive(0, 0, 0, 1, 1, 10);
    look(12);
    drive(0, 0, 0, 1, 1, 12);
    look(10);

    phase = "R1";
    drive(1, 0, 13, 1, 1, 13);
    look(13);
    drive(1, 0, 13, 0, 1, 13);
    look(13);

    phase = "R7";
    thresh = TW'(100);
    look(10); look(12); look(13); look(99);
    thresh = TW'(4094);
    look(12);
    thresh = TW'(4095);
    look(12);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);

    phase = "R6";
    do_reset();
    thresh = '0;
    for (int k = 0; k < N; k++) begin
      drive(1, 0, 100 + k, 0, 0, 0);
      drive(1, 1, 100 + k, 0, 0, 0);
    end
    look(100);
    drive(1, 0, 200, 0, 1, 200);
    look(100); look(200); look(101);
    drive(1, 0, 201, 0, 1, 201);
    for (int k = 0; k < N; k++) look(100 + k);
    look(200); look(201);
    do_reset();
    for (int k = 0; k < N; k++) drive(1, 0, 50 + k, 0, 0, 0);
    for (int k = 0; k < N; k++) drive(1, 1, 50 + k, 0, 0, 0);
    drive(1, 0, 150, 0, 1, 81);
    for (int k = 0; k < N; k++) look(50 + k);
    look(150);

    phase = "R8";
    for (int c = 0; c < 4000; c++) begin
      if (c % 100 == 0) thresh = TW'($urandom_range(0, 300));
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 47),
            $urandom_range(0, 59) == 0, $urandom_range(0, 7) != 0, $urandom_range(0, 47));
    end
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule